// File: doc/BRIEF.md
# Autonomous Configuration Image Loader

This block copies a partial configuration image from an external word-addressed SRAM into a 32-bit internal configuration access port without help from the management processor. The master places a first word address and a word count on the request inputs and pulses a start strobe. From then on the loader fetches the words in ascending address order and streams them into the port. When the last word has been accepted, it raises a sticky interrupt toward the master.

SRAM reads return data a fixed number of cycles after the read strobe (two by default). The loader keeps several reads in flight and holds returned words in a small skid buffer. With the port ready, it writes one word every clock, which at a 100 MHz port clock is 400 MB/s. The port's busy input holds back the write strobe, and read issue halts once the buffer and the reads in flight fill every slot. No word is dropped or repeated.

Top module: `cfg_image_loader`

## Requirements
- R1: After reset, `xfer_busy`, `irq`, `port_we` and `sram_re` are all low.
- R2: A start with a word count N greater than zero produces exactly N port writes. Write k (counting from 0) carries the SRAM word at address `req_addr + k`.
- R3: With `port_busy` held low, the N writes of a transfer occupy N consecutive clock cycles.
- R4: SRAM data is taken exactly LAT cycles (default 2) after the cycle in which `sram_re` was high for its address. `sram_re` is only high while `xfer_busy` is high.
- R5: `port_we` is never high in a cycle where `port_busy` is high. Under any busy pattern, the written sequence is still the R2 sequence with no word lost or duplicated.
- R6: `xfer_busy` rises the cycle after an accepted start with N>0 and stays high through the cycle of the last write. In the following cycle `irq` is high and `xfer_busy` is low.
- R7: A start with a word count of zero issues no SRAM read and no port write, and leaves `xfer_busy` low. `irq` is high in the next cycle.
- R8: A start pulse while `xfer_busy` is high is ignored, and the running transfer's sequence and length are unchanged.
- R9: `irq` stays high until a cycle with `irq_ack` high, and is low in the cycle after. If a completion falls in the same cycle as `irq_ack`, `irq` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the SRAM and the port |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_addr | input | AW (16) | First SRAM word address of the image |
| req_len | input | LW (16) | Image length in 32-bit words |
| req_start | input | 1 | Single-cycle start strobe |
| irq_ack | input | 1 | Clears the completion interrupt |
| sram_re | output | 1 | SRAM read strobe |
| sram_addr | output | AW (16) | SRAM word address for the read |
| sram_rdata | input | 32 | SRAM read data, valid LAT cycles after the strobe |
| port_we | output | 1 | Configuration port write strobe |
| port_data | output | 32 | Configuration port write data |
| port_busy | input | 1 | Port cannot accept a word this cycle |
| xfer_busy | output | 1 | Transfer in progress |
| irq | output | 1 | Sticky completion interrupt |

## Verification
A wrong address counter or an off-by-one latency stage shows up on the first port write as a data word that does not match its address. That happens four cycles after the start strobe. A lost or duplicated buffer entry shows up as a shifted sequence on the next write after a busy stall, and a broken word counter shows up as an early or late interrupt in the cycle after the last write. The bench predicts every write from its own address queue and compares on each clock, so each of these faults is reported in the cycle where it appears.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

  localparam int unsigned WORD_W = 32;

  typedef logic [WORD_W-1:0] cfg_word_t;

  // Wrap-around increment for a ring index of arbitrary depth.
  function automatic int unsigned ring_next(input int unsigned idx, input int unsigned depth);
    return (idx + 1 >= depth) ? 0 : idx + 1;
  endfunction

  // True when one more read can be launched without overrunning the buffer.
  function automatic logic slot_free(input int unsigned in_flight, input int unsigned held,
                                     input int unsigned depth);
    return (in_flight + held) < depth;
  endfunction

endpackage

// File: rtl/cfgl_fetch.sv
module cfgl_fetch
  import cfgl_pkg::*;
#(
  parameter int unsigned AW    = 16,
  parameter int unsigned LW    = 16,
  parameter int unsigned LAT   = 2,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic [LW-1:0] len,
  input  logic [CW-1:0] held,
  output logic          rd_strobe,
  output logic [AW-1:0] rd_addr,
  output logic          rd_valid
);

  logic [AW-1:0]  addr_q;
  logic [LW-1:0]  remain_q;
  logic [LAT-1:0] vld_pipe;
  logic           has_room;

  assign has_room  = slot_free($countones(vld_pipe), int'(held), DEPTH);
  assign rd_strobe = (remain_q != '0) && has_room;
  assign rd_addr   = addr_q;
  assign rd_valid  = vld_pipe[LAT-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      remain_q <= '0;
    end else if (load) begin
      addr_q   <= base;
      remain_q <= len;
    end else if (rd_strobe) begin
      addr_q   <= addr_q + 1'b1;
      remain_q <= remain_q - 1'b1;
    end
  end

  // Latency tracker: one valid bit per read in flight.
  generate
    if (LAT == 1) begin : g_lat1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_pipe <= '0;
        else        vld_pipe <= rd_strobe;
      end
    end else begin : g_latn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_pipe <= '0;
        else        vld_pipe <= {vld_pipe[LAT-2:0], rd_strobe};
      end
    end
  endgenerate

  assert_addr_ascend_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !load) |=> (rd_addr == $past(rd_addr) + 1'b1));

  assert_read_credit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |-> ((int'(held) + $countones(vld_pipe)) < DEPTH));

endmodule

// File: rtl/cfgl_fifo.sv
module cfgl_fifo
  import cfgl_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  cfg_word_t     din,
  input  logic          pop,
  output cfg_word_t     dout,
  output logic          empty,
  output logic [CW-1:0] count
);

  cfg_word_t     slots [DEPTH];
  logic [PW-1:0] wr_idx, rd_idx;

  assign empty = (count == '0);
  assign dout  = slots[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_idx <= '0;
      rd_idx <= '0;
      count  <= '0;
    end else begin
      if (push) wr_idx <= PW'(ring_next(int'(wr_idx), DEPTH));
      if (pop)  rd_idx <= PW'(ring_next(int'(rd_idx), DEPTH));
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) slots[wr_idx] <= din;
  end

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |-> (int'(count) < DEPTH));

  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/cfgl_ctrl.sv
module cfgl_ctrl #(
  parameter int unsigned LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_start,
  input  logic [LW-1:0] req_len,
  input  logic          irq_ack,
  input  logic          wr_fire,
  output logic          load,
  output logic          active,
  output logic          irq
);

  logic [LW-1:0] left_q;
  logic          accept, zero_done, last_fire, done_evt;

  assign accept    = req_start && !active;
  assign zero_done = accept && (req_len == '0);
  assign load      = accept && (req_len != '0);
  assign last_fire = active && wr_fire && (left_q == LW'(1));
  assign done_evt  = zero_done || last_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      left_q <= '0;
      irq    <= 1'b0;
    end else begin
      if (load)           active <= 1'b1;
      else if (last_fire) active <= 1'b0;

      if (load)         left_q <= req_len;
      else if (wr_fire) left_q <= left_q - 1'b1;

      irq <= (irq && !irq_ack) || done_evt;
    end
  end

  assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack) |=> irq);

  assert_ack_wins_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !done_evt) |=> !irq);

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && req_start && !wr_fire) |=> $stable(left_q));

  assert_zero_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && req_start && (req_len == '0)) |=> (irq && !active));

  assert_done_then_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    last_fire |=> (!active && irq));

endmodule

// File: rtl/cfg_image_loader.sv
module cfg_image_loader
  import cfgl_pkg::*;
#(
  parameter int unsigned AW    = 16,
  parameter int unsigned LW    = 16,
  parameter int unsigned LAT   = 2,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] req_addr,
  input  logic [LW-1:0] req_len,
  input  logic          req_start,
  input  logic          irq_ack,
  output logic          sram_re,
  output logic [AW-1:0] sram_addr,
  input  logic [31:0]   sram_rdata,
  output logic          port_we,
  output logic [31:0]   port_data,
  input  logic          port_busy,
  output logic          xfer_busy,
  output logic          irq
);

  logic          load, active, rd_valid, buf_empty;
  logic [CW-1:0] buf_count;
  cfg_word_t     buf_head;

  cfgl_ctrl #(.LW(LW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_start (req_start),
    .req_len   (req_len),
    .irq_ack   (irq_ack),
    .wr_fire   (port_we),
    .load      (load),
    .active    (active),
    .irq       (irq)
  );

  cfgl_fetch #(.AW(AW), .LW(LW), .LAT(LAT), .DEPTH(DEPTH)) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .base      (req_addr),
    .len       (req_len),
    .held      (buf_count),
    .rd_strobe (sram_re),
    .rd_addr   (sram_addr),
    .rd_valid  (rd_valid)
  );

  cfgl_fifo #(.DEPTH(DEPTH)) u_buf (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (rd_valid),
    .din   (sram_rdata),
    .pop   (port_we),
    .dout  (buf_head),
    .empty (buf_empty),
    .count (buf_count)
  );

  assign port_we   = active && !buf_empty && !port_busy;
  assign port_data = buf_head;
  assign xfer_busy = active;

  assert_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    port_busy |-> !port_we);

  assert_read_when_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sram_re |-> xfer_busy);

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_busy |-> (!port_we && !sram_re));

endmodule

// File: tb/cfg_image_loader_tb.sv
module cfg_image_loader_tb;

  localparam int AW = 16;
  localparam int LW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic          req_start = 1'b0;
  logic          irq_ack = 1'b0;
  logic          sram_re;
  logic [AW-1:0] sram_addr;
  logic [31:0]   sram_rdata;
  logic          port_we;
  logic [31:0]   port_data;
  logic          port_busy = 1'b0;
  logic          xfer_busy;
  logic          irq;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int busy_period = 0;
  int first_wr = -1;
  int last_wr = -1;
  int writes_seen = 0;
  bit done_pending = 1'b0;
  bit finished = 1'b0;
  logic [31:0] exp_q[$];
  logic [31:0] sram_d1;

  cfg_image_loader u_dut (
    .clk(clk), .rst_n(rst_n), .req_addr(req_addr), .req_len(req_len),
    .req_start(req_start), .irq_ack(irq_ack), .sram_re(sram_re),
    .sram_addr(sram_addr), .sram_rdata(sram_rdata), .port_we(port_we),
    .port_data(port_data), .port_busy(port_busy), .xfer_busy(xfer_busy), .irq(irq)
  );

  always #5 clk = ~clk;

  function automatic logic [31:0] word_at(input logic [AW-1:0] a);
    return {a, a ^ 16'h5A3C};
  endfunction

  // Behavioural SRAM: two register stages between strobe and data.
  always @(posedge clk) begin
    if (sram_re) sram_d1 <= word_at(sram_addr);
    sram_rdata <= sram_d1;
  end

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Reference model, compared every clock at the falling edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (done_pending) begin
        check(irq == 1'b1, "R6", "irq after last write", 32'(irq), 32'd1);
        check(xfer_busy == 1'b0, "R6", "xfer_busy after last write", 32'(xfer_busy), 32'd0);
        done_pending = 1'b0;
      end else if (exp_q.size() != 0 && writes_seen > 0) begin
        check(xfer_busy == 1'b1, "R6", "xfer_busy during transfer", 32'(xfer_busy), 32'd1);
      end
      if (sram_re)
        check(xfer_busy == 1'b1, "R4", "read strobe while idle", 32'(xfer_busy), 32'd1);
      if (port_we) begin
        check(port_busy == 1'b0, "R5", "write during busy", 32'(port_busy), 32'd0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R2", "unexpected write", port_data, 32'hx);
        end else begin
          check(port_data == exp_q[0], "R2", "write data", port_data, exp_q[0]);
          void'(exp_q.pop_front());
          if (first_wr < 0) first_wr = cyc;
          last_wr = cyc;
          writes_seen++;
          if (exp_q.size() == 0) done_pending = 1'b1;
        end
      end
    end
  end

  // Port busy pattern generator.
  initial begin
    forever begin
      @(posedge clk); #2;
      port_busy = (busy_period > 0) ? ((cyc % busy_period) == 0 || (cyc % 7) == 3) : 1'b0;
    end
  end

  task automatic start_xfer(input logic [AW-1:0] a, input logic [LW-1:0] n);
    @(posedge clk); #2;
    for (int k = 0; k < int'(n); k++) exp_q.push_back(word_at(a + AW'(k)));
    first_wr = -1; last_wr = -1; writes_seen = 0;
    req_addr = a; req_len = n; req_start = 1'b1;
    @(posedge clk); #2;
    req_start = 1'b0;
  endtask

  task automatic wait_irq(input string req);
    int guard = 0;
    while (!irq && guard < 5000) begin @(negedge clk); guard++; end
    check(irq == 1'b1, req, "interrupt seen", 32'(irq), 32'd1);
  endtask

  task automatic ack_irq();
    @(posedge clk); #2; irq_ack = 1'b1;
    @(posedge clk); #2; irq_ack = 1'b0;
    @(negedge clk);
    check(irq == 1'b0, "R9", "irq cleared by ack", 32'(irq), 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({xfer_busy, irq, port_we, sram_re} == 4'b0, "R1", "outputs in reset",
          32'({xfer_busy, irq, port_we, sram_re}), 32'd0);
    #2 rst_n = 1'b1;
    @(negedge clk);
    check({xfer_busy, irq, port_we, sram_re} == 4'b0, "R1", "outputs after reset",
          32'({xfer_busy, irq, port_we, sram_re}), 32'd0);

    // R2 R3: streaming, no stall.
    start_xfer(16'h0100, 16'd12);
    wait_irq("R2");
    check(writes_seen == 12, "R2", "write count", 32'(writes_seen), 32'd12);
    check(last_wr - first_wr == 11, "R3", "back-to-back span", 32'(last_wr - first_wr), 32'd11);
    // R9: interrupt holds with no acknowledge.
    repeat (5) @(negedge clk);
    check(irq == 1'b1, "R9", "irq sticky", 32'(irq), 32'd1);
    ack_irq();

    // R3 boundary: single word.
    start_xfer(16'hFFFF, 16'd1);
    wait_irq("R2");
    check(writes_seen == 1, "R2", "single word count", 32'(writes_seen), 32'd1);
    ack_irq();

    // R4 R5: port stalls, address wrap.
    busy_period = 3;
    start_xfer(16'hFFF8, 16'd20);
    wait_irq("R5");
    check(writes_seen == 20, "R5", "count under stalls", 32'(writes_seen), 32'd20);
    check(exp_q.size() == 0, "R5", "nothing missing", 32'(exp_q.size()), 32'd0);
    ack_irq();
    busy_period = 2;
    start_xfer(16'h2000, 16'd9);
    wait_irq("R5");
    check(writes_seen == 9, "R5", "count heavy stalls", 32'(writes_seen), 32'd9);
    ack_irq();
    busy_period = 0;

    // R8: start during a transfer is ignored.
    start_xfer(16'h0300, 16'd10);
    @(posedge clk); #2;
    req_addr = 16'h7777; req_len = 16'd3; req_start = 1'b1;
    @(posedge clk); #2;
    req_start = 1'b0;
    wait_irq("R8");
    check(writes_seen == 10, "R8", "length unchanged", 32'(writes_seen), 32'd10);
    ack_irq();

    // R7: zero-length request.
    @(posedge clk); #2;
    req_addr = 16'h4000; req_len = 16'd0; req_start = 1'b1;
    @(negedge clk);
    check(xfer_busy == 1'b0, "R7", "no busy on zero length", 32'(xfer_busy), 32'd0);
    @(posedge clk); #2; req_start = 1'b0;
    @(negedge clk);
    check(irq == 1'b1, "R7", "irq next cycle", 32'(irq), 32'd1);
    check(xfer_busy == 1'b0, "R7", "still idle", 32'(xfer_busy), 32'd0);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0 && !port_we, "R7", "no writes", 32'(port_we), 32'd0);
    ack_irq();

    // R9: acknowledge in the same cycle as completion.
    start_xfer(16'h0500, 16'd6);
    begin
      int guard = 0;
      while (exp_q.size() != 1 && guard < 5000) begin @(negedge clk); #1; guard++; end
    end
    @(posedge clk); #2; irq_ack = 1'b1;
    @(posedge clk); #2; irq_ack = 1'b0;
    @(negedge clk);
    check(irq == 1'b1, "R9", "completion beats ack", 32'(irq), 32'd1);
    ack_irq();

    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule